// File: doc/BRIEF.md
# Hex Record Loader with Per-Record Acknowledge

This block takes over a serial byte stream once a command front end has selected a load or a verify operation. It reads ASCII hexadecimal records, each opened by a colon. A record carries a byte count, a 16-bit start address, a record type, the data and a checksum. The block decodes the hex pairs, keeps a running 8-bit sum and holds the data bytes in a small record buffer. A record is accepted only when its checksum is good and its type is known.

In load mode an accepted data record is copied from the buffer to a synchronous memory port, one byte per cycle. In verify mode the same record is read back from that port and compared byte by byte. In both modes exactly one response byte goes out per record: 0x41 ('A') for an accepted record, 0x4E ('N') otherwise.

The block is started by a one-cycle pulse and confirms entry with an 'A'. An end-of-file record is acknowledged with 'A', after which the block goes idle and returns control to the front end with a one-cycle pulse. The sender waits for each response before it sends the next record. Bytes that arrive while a record is being committed or compared are not consumed.

Top module: `hex_record_loader`

## Requirements
- R1: After reset the block is idle: `active_o` low, no response byte, no memory write, and received bytes are ignored until a start pulse arrives.
- R2: A start pulse while idle latches `verify_i` as the mode, raises `active_o` and sends one 0x41 in the next cycle.
- R3: In load mode a data record (type 0x00) with a good checksum writes its data bytes, in order, to address+i and then sends 0x41. No write happens before the checksum character has been received.
- R4: The 8-bit sum of all decoded bytes, including the checksum, must be zero. Otherwise the record is answered with 0x4E and nothing is written.
- R5: A record whose type is neither 0x00 nor 0x01 is answered with 0x4E and writes nothing, even when its checksum is good.
- R6: An end-of-file record (type 0x01) with a good checksum is answered with 0x41. In the same cycle `done_o` pulses, and `active_o` is low from that cycle on.
- R7: In verify mode no write is issued. A data record is answered with 0x41 when every byte equals memory, and with 0x4E when any byte differs.
- R8: Hex digits are accepted in upper or lower case. A non-hex character inside a record sends 0x4E at once and drops the record, and input is ignored until the next ':'. A ':' inside a record also sends 0x4E, but it starts a new record.
- R9: A byte count above `MAXLEN` sends 0x4E as soon as the count field is complete. The rest of that record is ignored.
- R10: Write and read addresses are address+i taken modulo 2^`AW`.
- R11: Characters outside a record, before the ':' that opens one, produce no response.
- R12: A data record with a byte count of zero and a good checksum is answered with 0x41 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse: enter load or verify mode |
| verify_i | input | 1 | Mode sampled with start: 1 verify, 0 load |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received ASCII character |
| tx_valid_o | output | 1 | Response byte strobe |
| tx_data_o | output | 8 | Response byte, 0x41 or 0x4E |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |
| active_o | output | 1 | High while in load or verify mode |
| done_o | output | 1 | One-cycle pulse when end of file ends the mode |

## Verification
The bench builds the block with `AW` = 10 and `MAXLEN` = 8. The eight-byte buffer lets a nine-byte count exercise the overflow abort with short records. The 1024-byte address space lets a record placed at 0x03FE show the wrap-around. Both values also keep the bench memory small while still filling the buffer completely in some records.

// File: rtl/hex_record_loader.sv
module hex_record_loader #(
  parameter int AW     = 16,
  parameter int MAXLEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          verify_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_we_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          active_o,
  output logic          done_o
);
  localparam int         KW   = $clog2(MAXLEN + 1);
  localparam int         IW   = $clog2(MAXLEN + 5);
  localparam logic [7:0] MAXB = 8'(MAXLEN);
  localparam logic [7:0] ACK  = 8'h41;
  localparam logic [7:0] NAK  = 8'h4E;
  localparam logic [7:0] SOR  = 8'h3A;

  typedef enum logic [2:0] {S_IDLE, S_SYNC, S_HEX, S_WR, S_VER} st_t;

  st_t            st_q;
  logic           verify_q, half_q, miss_q;
  logic [3:0]     nib_q;
  logic [IW-1:0]  bidx_q;
  logic [7:0]     cnt_q, type_q, sum_q;
  logic [15:0]    base_q;
  logic [KW-1:0]  k_q;
  logic [7:0]     dbuf_q [MAXLEN];
  logic           tx_valid_q, done_q;
  logic [7:0]     tx_data_q;

  logic           hv;
  logic [3:0]     hn;
  logic [7:0]     byte_w, sum_n;
  logic           is_ck, take_byte, dbuf_we, mis_now, wr_last;

  always_comb begin
    hv = 1'b1;
    hn = 4'd0;
    if (rx_data_i >= 8'h30 && rx_data_i <= 8'h39)      hn = rx_data_i[3:0];
    else if (rx_data_i >= 8'h41 && rx_data_i <= 8'h46) hn = rx_data_i[3:0] + 4'd9;
    else if (rx_data_i >= 8'h61 && rx_data_i <= 8'h66) hn = rx_data_i[3:0] + 4'd9;
    else                                               hv = 1'b0;
  end

  assign byte_w    = {nib_q, hn};
  assign sum_n     = sum_q + byte_w;
  assign is_ck     = ({1'b0, cnt_q} + 9'd4) == 9'(bidx_q);
  assign take_byte = (st_q == S_HEX) && rx_valid_i && hv && half_q;
  assign dbuf_we   = take_byte && (bidx_q >= IW'(4)) && !is_ck;
  assign mis_now   = (k_q != '0) && (mem_rdata_i != dbuf_q[k_q - KW'(1)]);
  assign wr_last   = (8'(k_q) + 8'd1) == cnt_q;

  always_ff @(posedge clk) begin
    if (dbuf_we) dbuf_q[KW'(bidx_q - IW'(4))] <= byte_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      verify_q   <= 1'b0;
      half_q     <= 1'b0;
      miss_q     <= 1'b0;
      nib_q      <= '0;
      bidx_q     <= '0;
      cnt_q      <= '0;
      type_q     <= '0;
      sum_q      <= '0;
      base_q     <= '0;
      k_q        <= '0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      tx_valid_q <= 1'b0;
      done_q     <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          verify_q   <= verify_i;
          st_q       <= S_SYNC;
          tx_valid_q <= 1'b1;
          tx_data_q  <= ACK;
        end
        S_SYNC: if (rx_valid_i && rx_data_i == SOR) begin
          st_q   <= S_HEX;
          half_q <= 1'b0;
          bidx_q <= '0;
          sum_q  <= '0;
        end
        S_HEX: if (rx_valid_i) begin
          if (rx_data_i == SOR) begin
            tx_valid_q <= 1'b1;
            tx_data_q  <= NAK;
            half_q     <= 1'b0;
            bidx_q     <= '0;
            sum_q      <= '0;
          end else if (!hv) begin
            tx_valid_q <= 1'b1;
            tx_data_q  <= NAK;
            st_q       <= S_SYNC;
          end else if (!half_q) begin
            nib_q  <= hn;
            half_q <= 1'b1;
          end else begin
            half_q <= 1'b0;
            sum_q  <= sum_n;
            bidx_q <= bidx_q + IW'(1);
            if (bidx_q == IW'(0)) begin
              cnt_q <= byte_w;
              if (byte_w > MAXB) begin
                tx_valid_q <= 1'b1;
                tx_data_q  <= NAK;
                st_q       <= S_SYNC;
              end
            end else if (bidx_q == IW'(1)) begin
              base_q[15:8] <= byte_w;
            end else if (bidx_q == IW'(2)) begin
              base_q[7:0] <= byte_w;
            end else if (bidx_q == IW'(3)) begin
              type_q <= byte_w;
            end else if (is_ck) begin
              k_q    <= '0;
              miss_q <= 1'b0;
              if (sum_n != 8'd0 || type_q > 8'd1) begin
                tx_valid_q <= 1'b1;
                tx_data_q  <= NAK;
                st_q       <= S_SYNC;
              end else if (type_q == 8'd1) begin
                tx_valid_q <= 1'b1;
                tx_data_q  <= ACK;
                done_q     <= 1'b1;
                st_q       <= S_IDLE;
              end else if (cnt_q == 8'd0) begin
                tx_valid_q <= 1'b1;
                tx_data_q  <= ACK;
                st_q       <= S_SYNC;
              end else begin
                st_q <= verify_q ? S_VER : S_WR;
              end
            end
          end
        end
        S_WR: begin
          k_q <= k_q + KW'(1);
          if (wr_last) begin
            tx_valid_q <= 1'b1;
            tx_data_q  <= ACK;
            st_q       <= S_SYNC;
          end
        end
        S_VER: begin
          if (8'(k_q) == cnt_q) begin
            tx_valid_q <= 1'b1;
            tx_data_q  <= (miss_q || mis_now) ? NAK : ACK;
            st_q       <= S_SYNC;
          end else begin
            k_q    <= k_q + KW'(1);
            miss_q <= miss_q | mis_now;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_we_o    = (st_q == S_WR);
  assign mem_wdata_o = dbuf_q[k_q];
  assign mem_addr_o  = AW'(base_q + 16'(k_q));
  assign active_o    = (st_q != S_IDLE);
  assign tx_valid_o  = tx_valid_q;
  assign tx_data_o   = tx_data_q;
  assign done_o      = done_q;
endmodule

module hex_record_loader_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       mem_we_o,
  input logic       active_o,
  input logic       done_o,
  input logic       verify_q
);
  a_r2_start_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !active_o) |=> (tx_valid_o && tx_data_o == 8'h41 && active_o));

  a_r4_code_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> (tx_data_o == 8'h41 || tx_data_o == 8'h4E));

  a_r3_write_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (active_o && !tx_valid_o));

  a_r7_verify_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !verify_q);

  a_r6_done_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (tx_valid_o && tx_data_o == 8'h41 && !active_o));

  a_r6_done_leaves_mode: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(active_o));

  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !start_i) |=> !tx_valid_o || done_o);
endmodule

bind hex_record_loader hex_record_loader_checks u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .mem_we_o   (mem_we_o),
  .active_o   (active_o),
  .done_o     (done_o),
  .verify_q   (verify_q)
);

// File: tb/tb_hex_record_loader.sv
`timescale 1ns/1ps
module tb_hex_record_loader;
  localparam int AW = 10;
  localparam int ML = 8;
  localparam int MS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, verify_i = 1'b0;
  logic          rx_valid_i = 1'b0;
  logic [7:0]    rx_data_i = 8'h00;
  logic          tx_valid_o, mem_we_o, active_o, done_o;
  logic [7:0]    tx_data_o, mem_wdata_o;
  logic [7:0]    mem_rdata_i;
  logic [AW-1:0] mem_addr_o;

  always #5 clk = ~clk;

  hex_record_loader #(.AW(AW), .MAXLEN(ML)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .verify_i(verify_i),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
    .mem_rdata_i(mem_rdata_i), .active_o(active_o), .done_o(done_o));

  logic [7:0] mem [MS];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MS; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    end
    mem_rdata_i <= mem[mem_addr_o];
  end

  function automatic logic [7:0] init_val(input int a);
    return 8'(a * 7 + 3);
  endfunction

  logic [7:0] tx_log[$];
  int wr_cnt = 0, done_cnt = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (tx_valid_o) tx_log.push_back(tx_data_o);
    if (mem_we_o) wr_cnt++;
    if (done_o) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    rx_valid_i = 1'b1;
    rx_data_i  = c;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  function automatic string hx(input logic [7:0] v, input bit lower);
    return lower ? $sformatf("%02x", v) : $sformatf("%02X", v);
  endfunction

  function automatic string rec_str(input logic [7:0] n, input logic [15:0] a,
                                    input logic [7:0] typ, input logic [7:0] d [8],
                                    input bit bad, input bit lower);
    logic [7:0] s;
    string r;
    s = n + a[15:8] + a[7:0] + typ;
    r = {":", hx(n, lower), hx(a[15:8], lower), hx(a[7:0], lower), hx(typ, lower)};
    for (int i = 0; i < int'(n); i++) begin
      s = s + d[i];
      r = {r, hx(d[i], lower)};
    end
    s = 8'd0 - s;
    if (bad) s = s ^ 8'h01;
    return {r, hx(s, lower)};
  endfunction

  task automatic expect_resp(input logic [7:0] exp, input string req);
    int w = 0;
    while (tx_log.size() == 0 && w < 40) begin
      @(negedge clk);
      w++;
    end
    repeat (3) @(negedge clk);
    chk(tx_log.size() == 1, req, tx_log.size(), 1);
    if (tx_log.size() >= 1) chk(tx_log[0] == exp, req, tx_log[0], exp);
    tx_log.delete();
  endtask

  task automatic expect_quiet(input string req);
    repeat (20) @(negedge clk);
    chk(tx_log.size() == 0, req, tx_log.size(), 0);
    tx_log.delete();
  endtask

  task automatic do_start(input bit v, input string req);
    @(negedge clk);
    start_i = 1'b1;
    verify_i = v;
    @(negedge clk);
    start_i = 1'b0;
    chk(tx_valid_o && tx_data_o == 8'h41, req, tx_data_o, 8'h41);
    chk(active_o, req, active_o, 1);
    repeat (2) @(negedge clk);
    tx_log.delete();
  endtask

  logic [7:0] dz [8] = '{default: 8'h00};
  logic [7:0] d1 [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
  logic [7:0] d2 [8] = '{8'hA0, 8'hB1, 8'hC2, 8'hD3, 8'hE4, 8'hF5, 8'h06, 8'h17};

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!active_o && !tx_valid_o && !mem_we_o, "R1 reset state", active_o, 0);
    send_str(":00000001FF");
    expect_quiet("R1 idle ignores input");
  endtask

  task automatic t_noise;
    send_str("\r\nzz01");
    expect_quiet("R11 no reply outside record");
  endtask

  task automatic t_load_basic;
    string s;
    int w0;
    s = rec_str(8'd4, 16'h0010, 8'h00, d1, 1'b0, 1'b0);
    w0 = wr_cnt;
    send_str(s.substr(0, s.len() - 2));
    repeat (4) @(negedge clk);
    chk(wr_cnt == w0, "R3 no write before checksum", wr_cnt - w0, 0);
    send_char(s[s.len() - 1]);
    expect_resp(8'h41, "R3 ack after load");
    chk(wr_cnt - w0 == 4, "R3 write count", wr_cnt - w0, 4);
    for (int i = 0; i < 4; i++)
      chk(mem[16 + i] == d1[i], "R3 data stored", mem[16 + i], d1[i]);
  endtask

  task automatic t_full_buffer;
    int w0 = wr_cnt;
    send_str(rec_str(8'd8, 16'h0100, 8'h00, d2, 1'b0, 1'b0));
    expect_resp(8'h41, "R3 full buffer ack");
    chk(wr_cnt - w0 == 8, "R3 full buffer writes", wr_cnt - w0, 8);
    chk(mem[256 + 7] == d2[7], "R3 last byte", mem[263], d2[7]);
  endtask

  task automatic t_bad_sum;
    int w0 = wr_cnt;
    send_str(rec_str(8'd3, 16'h0040, 8'h00, d1, 1'b1, 1'b0));
    expect_resp(8'h4E, "R4 bad checksum nak");
    chk(wr_cnt == w0, "R4 no write", wr_cnt - w0, 0);
    chk(mem[64] == init_val(64), "R4 memory kept", mem[64], init_val(64));
  endtask

  task automatic t_bad_type;
    int w0 = wr_cnt;
    send_str(rec_str(8'd2, 16'h0050, 8'h02, d1, 1'b0, 1'b0));
    expect_resp(8'h4E, "R5 unknown type nak");
    chk(wr_cnt == w0, "R5 no write", wr_cnt - w0, 0);
  endtask

  task automatic t_nonhex;
    int w0 = wr_cnt;
    send_str(":04001G");
    expect_resp(8'h4E, "R8 non-hex nak");
    send_str("0011223344");
    expect_quiet("R8 ignored until colon");
    send_str(rec_str(8'd2, 16'h0060, 8'h00, d2, 1'b0, 1'b1));
    expect_resp(8'h41, "R8 lower-case record ack");
    chk(wr_cnt - w0 == 2 && mem[96] == d2[0] && mem[97] == d2[1],
        "R8 lower-case data", mem[97], d2[1]);
  endtask

  task automatic t_restart;
    send_str(":0400");
    send_str(rec_str(8'd1, 16'h0070, 8'h00, d1, 1'b0, 1'b0));
    repeat (30) @(negedge clk);
    chk(tx_log.size() == 2, "R8 colon restart count", tx_log.size(), 2);
    if (tx_log.size() == 2) begin
      chk(tx_log[0] == 8'h4E, "R8 colon restart nak", tx_log[0], 8'h4E);
      chk(tx_log[1] == 8'h41, "R8 restarted record ack", tx_log[1], 8'h41);
    end
    tx_log.delete();
    chk(mem[112] == d1[0], "R8 restarted record data", mem[112], d1[0]);
  endtask

  task automatic t_overflow;
    int w0 = wr_cnt;
    send_str(":09");
    @(negedge clk);
    chk(tx_log.size() == 1 && tx_log[0] == 8'h4E, "R9 overflow nak at count",
        tx_log.size(), 1);
    tx_log.delete();
    send_str("0080000102030405060708090A");
    expect_quiet("R9 rest ignored");
    chk(wr_cnt == w0, "R9 no write", wr_cnt - w0, 0);
  endtask

  task automatic t_wrap;
    send_str(rec_str(8'd4, 16'h03FE, 8'h00, d2, 1'b0, 1'b0));
    expect_resp(8'h41, "R10 wrap ack");
    chk(mem[1022] == d2[0] && mem[1023] == d2[1], "R10 top bytes", mem[1023], d2[1]);
    chk(mem[0] == d2[2] && mem[1] == d2[3], "R10 wrapped bytes", mem[1], d2[3]);
  endtask

  task automatic t_zero_len;
    int w0 = wr_cnt;
    send_str(rec_str(8'd0, 16'h0200, 8'h00, dz, 1'b0, 1'b0));
    expect_resp(8'h41, "R12 empty record ack");
    chk(wr_cnt == w0, "R12 no write", wr_cnt - w0, 0);
  endtask

  task automatic t_eof(input string req);
    int d0 = done_cnt;
    send_str(rec_str(8'd0, 16'h0000, 8'h01, dz, 1'b0, 1'b0));
    expect_resp(8'h41, req);
    chk(done_cnt - d0 == 1, "R6 done pulse", done_cnt - d0, 1);
    chk(!active_o, "R6 mode left", active_o, 0);
  endtask

  task automatic t_verify;
    logic [7:0] dm [8];
    int w0 = wr_cnt;
    do_start(1'b1, "R2 start verify ack");
    send_str(rec_str(8'd4, 16'h0010, 8'h00, d1, 1'b0, 1'b0));
    expect_resp(8'h41, "R7 matching verify ack");
    dm = d1;
    dm[3] = 8'hFF;
    send_str(rec_str(8'd4, 16'h0010, 8'h00, dm, 1'b0, 1'b0));
    expect_resp(8'h4E, "R7 mismatch nak");
    dm = d1;
    dm[0] = 8'h00;
    send_str(rec_str(8'd4, 16'h0010, 8'h00, dm, 1'b0, 1'b0));
    expect_resp(8'h4E, "R7 first byte mismatch nak");
    send_str(rec_str(8'd4, 16'h03FE, 8'h00, d2, 1'b0, 1'b0));
    expect_resp(8'h41, "R7 wrapped verify ack");
    chk(wr_cnt == w0, "R7 no write in verify", wr_cnt - w0, 0);
    chk(mem[19] == d1[3], "R7 memory kept", mem[19], d1[3]);
    t_eof("R6 eof ack in verify");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    do_start(1'b0, "R2 start load ack");
    t_noise();
    t_load_basic();
    t_full_buffer();
    t_bad_sum();
    t_bad_type();
    t_nonhex();
    t_restart();
    t_overflow();
    t_wrap();
    t_zero_len();
    t_eof("R6 eof ack in load");
    send_str(rec_str(8'd1, 16'h0300, 8'h00, d1, 1'b0, 1'b0));
    expect_quiet("R1 idle after eof");
    t_verify();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule